// File: doc/BRIEF.md
# SPI Status-Register Write-Protection Front End

This block sits on the serial side of a byte-wide nonvolatile memory and owns its status register. It receives SPI mode 0 frames (chip select low, data sampled on the rising serial clock, data out changed on the falling clock), decodes four commands, and keeps the write-enable latch, a two-bit block-protect field and a status-lock bit. The serial inputs are brought into the system clock domain through synchronizers and handled from detected edges, so the system clock must run several times faster than the serial clock.

A status write is accepted only when three things agree: the write-enable latch, the status-lock bit and the live level of an active-low write-protect pin. When the lock bit is set and the pin is low, the register is frozen, and so is the array region chosen by the block-protect bits. This frozen state is reached whichever of the two happens first, and it ends only when the pin goes high. For any address on a 15-bit address port, the block reports whether a write to that byte would be blocked. A busy input stands in for the array engine, which is not part of this block.

Top module: `spi_status_guard`

## Requirements
- R1: After reset the lock bit is 0, block-protect is 00, the write-enable latch is 0, `spi_miso_oe` is 0 and `wr_blocked` is 0 for every address.
- R2: A frame of exactly 8 clocks with opcode 0x06 sets the write-enable latch when chip select rises. A frame of exactly 8 clocks with opcode 0x04 clears it. The same opcodes with any other clock count leave the latch unchanged.
- R3: A status write (opcode 0x01) is discarded when the write-enable latch is clear.
- R4: While the lock bit is 0, a status write with the latch set is accepted at any level of `wp_n`. Each accepted status write clears the latch.
- R5: While the lock bit is 1 and `wp_n` is high, a status write with the latch set is accepted.
- R6: While the lock bit is 1 and `wp_n` is low (protected mode), a status write is discarded, and the latch and all status bits stay unchanged. Protected mode is reached whether the bit is set before or after the pin goes low, and it ends only when the pin goes high.
- R7: A status write commits only when chip select rises right after the 16th clock (8 opcode bits, then 8 data bits, MSB first). With 15 or 17 clocks nothing changes.
- R8: Opcode 0x05 shifts the status byte out MSB first, changing on falling clocks, and repeats it for as long as chip select stays low. The status layout is: bit 7 lock, bits 3:2 block-protect, bit 1 write-enable latch, bit 0 busy, and bits 6:4 read 0. `spi_miso_oe` is high only while the byte is being shifted out.
- R9: While `busy_in` is high, every command except 0x05 is ignored. A status read still works and shows busy in bit 0.
- R10: One cycle after the address or the block-protect field changes, `wr_blocked` is set as follows: 00 blocks nothing, 01 blocks addresses with the top two bits 11, 10 blocks addresses with the top bit 1, and 11 blocks every address.
- R11: `spi_miso_oe` stays low for the whole of a status-write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the data-out pad; 0 means high impedance |
| wp_n | input | 1 | Write-protect pin, active low |
| busy_in | input | 1 | Array engine busy |
| chk_addr | input | 15 | Byte address to classify |
| wr_blocked | output | 1 | Registered: a write to `chk_addr` would be refused |

## Verification
The bench goes into protected mode by both routes: the pin falling after the lock is set, and the lock being set while the pin is already low. It then shows that a status write is refused and the latch is kept, and that raising the pin lets the same write through. A design that checked the pin only when the lock was written would take the refused write. A design that cleared the latch on a refusal would show bit 1 as 0. The bench also sends frames with 15, 17 and 9 clocks, and a design that committed on a count threshold would change the register there. It checks the region edges for each block-protect code, and it checks that commands are dropped while busy is high but a status read is still served.

// File: rtl/ssg_pkg.sv
package ssg_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;

  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bp_e;
endpackage

// File: rtl/ssg_sync.sv
module ssg_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= INIT;
        else if (g == 0) stg[g] <= d;
        else stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ssg_spi_rx.sv
module ssg_spi_rx
  import ssg_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n_s,
  input  logic             sck_s,
  input  logic             mosi_s,
  input  logic [7:0]       stat,
  output logic             frm_done,
  output logic [CNT_W-1:0] frm_bits,
  output logic [7:0]       frm_op,
  output logic             frm_lock,
  output logic [1:0]       frm_bp,
  output logic             miso,
  output logic             miso_oe
);
  localparam logic [CNT_W-1:0] CNT_OP  = CNT_W'(8);
  localparam logic [CNT_W-1:0] CNT_SR  = CNT_W'(16);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic             sck_q, cs_q;
  logic             sck_rise, sck_fall;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       op_q, dat_q;
  logic [2:0]       rd_idx;

  assign sck_rise = sck_s & ~sck_q & ~cs_n_s;
  assign sck_fall = ~sck_s & sck_q & ~cs_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_n_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      op_q    <= '0;
      dat_q   <= '0;
      rd_idx  <= 3'd7;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else if (cs_n_s) begin
      cnt     <= '0;
      rd_idx  <= 3'd7;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      if (sck_rise) begin
        if (cnt < CNT_OP) op_q <= {op_q[6:0], mosi_s};
        else if (cnt < CNT_SR) dat_q <= {dat_q[6:0], mosi_s};
        if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
      end
      if (sck_fall && cnt >= CNT_OP && op_q == OP_RDSR) begin
        miso    <= stat[rd_idx];
        miso_oe <= 1'b1;
        rd_idx  <= rd_idx - 1'b1;
      end
    end
  end

  assign frm_done = cs_n_s & ~cs_q;
  assign frm_bits = cnt;
  assign frm_op   = op_q;
  assign frm_lock = dat_q[7];
  assign frm_bp   = dat_q[3:2];

  // R8 / R11: the output driver is only enabled inside a status read
  p_oe_read_only_r8: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> (op_q == OP_RDSR));
  p_oe_idle_r11: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n_s) |-> !miso_oe);
endmodule

// File: rtl/ssg_prot_regs.sv
module ssg_prot_regs
  import ssg_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_done,
  input  logic [CNT_W-1:0] frm_bits,
  input  logic [7:0]       frm_op,
  input  logic             frm_lock,
  input  logic [1:0]       frm_bp,
  input  logic             wp_n_s,
  input  logic             busy_s,
  output logic             lock,
  output logic [1:0]       bp,
  output logic             wel
);
  localparam logic [CNT_W-1:0] CNT_OP = CNT_W'(8);
  localparam logic [CNT_W-1:0] CNT_SR = CNT_W'(16);

  logic cmd_ok, do_wren, do_wrdi, frozen, do_wrsr;

  assign cmd_ok  = frm_done & ~busy_s;
  assign do_wren = cmd_ok && frm_bits == CNT_OP && frm_op == OP_WREN;
  assign do_wrdi = cmd_ok && frm_bits == CNT_OP && frm_op == OP_WRDI;
  assign frozen  = lock & ~wp_n_s;
  assign do_wrsr = cmd_ok && frm_bits == CNT_SR && frm_op == OP_WRSR && wel && !frozen;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock <= 1'b0;
      bp   <= BP_NONE;
      wel  <= 1'b0;
    end else begin
      if (do_wrsr) begin
        lock <= frm_lock;
        bp   <= frm_bp;
        wel  <= 1'b0;
      end else if (do_wren) begin
        wel <= 1'b1;
      end else if (do_wrdi) begin
        wel <= 1'b0;
      end
    end
  end

  // R1: reset state
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!lock && bp == 2'b00 && !wel));
  // R2: the latch only rises after a write-enable frame ends
  p_wel_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(frm_done && frm_op == OP_WREN && frm_bits == CNT_OP));
  // R3: no status change with the latch clear
  p_no_wel_no_write_r3: assert property (@(posedge clk) disable iff (rst)
    !wel |=> ($stable(bp) && $stable(lock)));
  // R4: a changed field means the latch was spent
  p_commit_clears_wel_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(bp) |-> !wel);
  // R6: protected mode freezes the register and the latch state
  p_frozen_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (lock && !wp_n_s) |=> ($stable(bp) && $stable(lock)));
  // R9: busy blocks latch changes
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
    busy_s |=> $stable(wel));
endmodule

// File: rtl/ssg_block_map.sv
module ssg_block_map
  import ssg_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              blocked
);
  localparam int TOP = ADDR_W - 1;

  logic hit;

  always_comb begin
    unique case (bp_e'(bp))
      BP_NONE:    hit = 1'b0;
      BP_QUARTER: hit = &addr[TOP -: 2];
      BP_HALF:    hit = addr[TOP];
      BP_ALL:     hit = 1'b1;
      default:    hit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) blocked <= 1'b0;
    else blocked <= hit;
  end

  // R10: end codes of the map
  p_all_locked_r10: assert property (@(posedge clk) disable iff (rst)
    (bp == 2'b11) |=> blocked);
  p_none_locked_r10: assert property (@(posedge clk) disable iff (rst)
    (bp == 2'b00) |=> !blocked);
endmodule

// File: rtl/spi_status_guard.sv
module spi_status_guard
  import ssg_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              wp_n,
  input  logic              busy_in,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              wr_blocked
);
  logic [4:0]       pins_s;
  logic             cs_n_s, sck_s, mosi_s, wp_n_s, busy_s;
  logic             frm_done, frm_lock;
  logic [CNT_W-1:0] frm_bits;
  logic [7:0]       frm_op, stat;
  logic [1:0]       frm_bp, bp;
  logic             lock, wel;

  ssg_sync #(.W(5), .STAGES(SYNC_STAGES), .INIT(5'b10010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_cs_n, spi_sck, spi_mosi, wp_n, busy_in}),
    .q   (pins_s)
  );
  assign {cs_n_s, sck_s, mosi_s, wp_n_s, busy_s} = pins_s;

  assign stat = {lock, 3'b000, bp, wel, busy_s};

  ssg_spi_rx #(.CNT_W(CNT_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .cs_n_s   (cs_n_s),
    .sck_s    (sck_s),
    .mosi_s   (mosi_s),
    .stat     (stat),
    .frm_done (frm_done),
    .frm_bits (frm_bits),
    .frm_op   (frm_op),
    .frm_lock (frm_lock),
    .frm_bp   (frm_bp),
    .miso     (spi_miso),
    .miso_oe  (spi_miso_oe)
  );

  ssg_prot_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .frm_done (frm_done),
    .frm_bits (frm_bits),
    .frm_op   (frm_op),
    .frm_lock (frm_lock),
    .frm_bp   (frm_bp),
    .wp_n_s   (wp_n_s),
    .busy_s   (busy_s),
    .lock     (lock),
    .bp       (bp),
    .wel      (wel)
  );

  ssg_block_map #(.ADDR_W(ADDR_W)) u_map (
    .clk     (clk),
    .rst     (rst),
    .bp      (bp),
    .addr    (chk_addr),
    .blocked (wr_blocked)
  );
endmodule

// File: tb/spi_status_guard_tb.sv
`timescale 1ns/1ps
module spi_status_guard_tb;
  localparam int HALF = 50;
  localparam int GAP  = 200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic        wp_n = 1'b1, busy_in = 1'b0;
  logic [14:0] chk_addr = '0;
  logic        spi_miso, spi_miso_oe, wr_blocked;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  spi_status_guard u_dut (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .wp_n(wp_n), .busy_in(busy_in), .chk_addr(chk_addr), .wr_blocked(wr_blocked)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: collects read bytes and compares them with the scoreboard
  logic [7:0] mon_sh = '0;
  int         mon_n = 0;
  always @(posedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) mon_n = 0;
    else if (spi_miso_oe) begin
      mon_sh = {mon_sh[6:0], spi_miso};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (exp_q.size() == 0) chk(0, "R8 unexpected byte", mon_sh, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(mon_sh == e, t, mon_sh, e);
        end
      end
    end
  end

  task automatic frame(input logic [31:0] bits, input int n, input logic exp_oe, input string req);
    spi_cs_n = 1'b0;
    #(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      spi_mosi = bits[i];
      #(HALF);
      spi_sck = 1'b1;
      #(HALF);
      spi_sck = 1'b0;
    end
    #(HALF);
    chk(spi_miso_oe == exp_oe, req, spi_miso_oe, exp_oe);
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    #(GAP);
  endtask

  task automatic rdsr(input logic [7:0] exp, input int nb, input string req);
    for (int i = 0; i < nb; i++) begin
      exp_q.push_back(exp);
      tag_q.push_back(req);
    end
    frame(32'h05 << (8 * nb), 8 + 8 * nb, 1'b1, "R8 oe during read");
  endtask

  task automatic wren();  frame(32'h06, 8, 1'b0, "R11 oe idle"); endtask
  task automatic wrdi();  frame(32'h04, 8, 1'b0, "R11 oe idle"); endtask
  task automatic wrsr(input logic [7:0] d);
    frame({16'h0, 8'h01, d}, 16, 1'b0, "R11 oe low in status write");
  endtask

  task automatic blk(input logic [14:0] a, input logic exp, input string req);
    chk_addr = a;
    repeat (3) @(negedge clk);
    chk(wr_blocked == exp, req, wr_blocked, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(spi_miso_oe == 1'b0, "R1 oe after reset", spi_miso_oe, 0);
    blk(15'h7FFF, 1'b0, "R1 nothing blocked after reset");
    rdsr(8'h00, 1, "R1 status after reset");
    // R3 status write without latch
    wrsr(8'h8C);
    rdsr(8'h00, 1, "R3 write without latch discarded");
    // R2 latch set / clear / wrong count
    wren();
    rdsr(8'h02, 1, "R2 latch set");
    wrdi();
    rdsr(8'h00, 1, "R2 latch cleared");
    frame(32'h0C, 9, 1'b0, "R11 oe idle");
    rdsr(8'h00, 1, "R2 nine-clock enable ignored");
    // R4 lock bit 0: accepted with pin low
    wren();
    wp_n = 1'b0;
    wrsr(8'h04);
    rdsr(8'h04, 1, "R4 accepted with pin low, latch cleared");
    blk(15'h6000, 1'b1, "R10 quarter edge blocked");
    blk(15'h5FFF, 1'b0, "R10 below quarter free");
    // R7 wrong clock counts
    wren();
    frame({16'h0, 8'h01, 8'h08} >> 1, 15, 1'b0, "R11 oe idle");
    rdsr(8'h06, 1, "R7 fifteen clocks aborted");
    frame({15'h0, 8'h01, 8'h08, 1'b0}, 17, 1'b0, "R11 oe idle");
    rdsr(8'h06, 1, "R7 seventeen clocks aborted");
    // R5 lock with pin high
    wp_n = 1'b1;
    #(GAP);
    wrsr(8'h88);
    rdsr(8'h88, 1, "R5 accepted with pin high");
    blk(15'h4000, 1'b1, "R10 half edge blocked");
    blk(15'h3FFF, 1'b0, "R10 below half free");
    // R6 order 1: pin falls after lock is set
    wren();
    wp_n = 1'b0;
    #(GAP);
    wrsr(8'h00);
    rdsr(8'h8A, 1, "R6 protected mode rejects, latch kept");
    blk(15'h7FFF, 1'b1, "R6 region stays locked");
    wp_n = 1'b1;
    #(GAP);
    wrsr(8'h00);
    rdsr(8'h00, 1, "R6 exit by pin high");
    // R6 order 2: lock set while pin already low
    wp_n = 1'b0;
    #(GAP);
    wren();
    wrsr(8'h8C);
    rdsr(8'h8C, 1, "R6 lock set with pin low");
    blk(15'h0000, 1'b1, "R10 all blocked");
    wren();
    wrsr(8'h00);
    rdsr(8'h8E, 1, "R6 second route rejects");
    wp_n = 1'b1;
    #(GAP);
    wrsr(8'h00);
    rdsr(8'h00, 1, "R6 second route exit");
    blk(15'h7FFF, 1'b0, "R10 none blocked");
    // R9 busy
    busy_in = 1'b1;
    #(GAP);
    wren();
    rdsr(8'h01, 1, "R9 command ignored while busy, read served");
    busy_in = 1'b0;
    #(GAP);
    rdsr(8'h00, 1, "R9 latch unchanged after busy");
    // R8 repeated read
    wren();
    rdsr(8'h02, 3, "R8 repeated status byte");
    chk(exp_q.size() == 0, "R8 all bytes seen", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule